// File: doc/BRIEF.md
# Real-Time Clock Control and Cross-Domain Synchronizer

This block owns the single control/status word of a real-time clock. It lives across two clock domains: a fast bus domain where software writes and reads the word, and a slow counting domain (nominally 32.768 kHz) where the seconds counters run. The counters themselves are outside the block; they are represented by an update strobe and two alarm-match pulses that arrive in the counting domain.

Changes to the run enable and to the two alarm interrupt enables are carried to the counting domain through a toggle request/acknowledge handshake. While that handshake is open, a busy bit reads 1 and those three bits are frozen. The run enable is further protected by a write-permit bit. The block also keeps a ready flag that tracks counter updates, latches two alarm pending flags, raises one interrupt line, reports whether counter reads may be trusted, and produces a square wave divided down from the counting clock.

Software issues a write with `bus_sel` and `bus_wr` high for one bus cycle; the word is always readable on `bus_rdata`. Word layout: bit 0 run enable, bit 1 time-of-day alarm interrupt enable, bit 2 sub-second alarm interrupt enable, bit 3 busy (read-only), bit 4 ready, bit 5 ready interrupt enable, bit 6 time-of-day alarm pending, bit 7 sub-second alarm pending, bit 8 square-wave enable, bits 10:9 square-wave rate, bit 11 free-running read mode, bit 15 write permit; bits 12 to 14 read 0.

Top module: `rtc_ctrl_sync`

## Requirements
- R1: After reset the whole word reads 0 (enables off, flags clear, busy 0, ready 0, rate 1 Hz, synchronous read mode), and `irq`, `rtc_run`, `sqw_out` and `ctr_rd_valid` are 0.
- R2: A write changes bit 0 only when bit 15 already holds 1 and busy is 0 at the write; otherwise bit 0 keeps its value.
- R3: An accepted write that changes bit 0, 1 or 2 sets busy (bit 3) from the next cycle; busy clears by itself once the counting domain has acknowledged through two-flop synchronizers in both directions; while busy is 1, writes to bits 0, 1 and 2 are ignored.
- R4: A new value of bits 1 and 2 gates `irq` only after busy has fallen, and by the time busy falls `rtc_run` equals bit 0.
- R5: Each `cnt_tick` while `rtc_run` is 1 first clears ready and, one counting cycle later, sets it; ticks while `rtc_run` is 0 are ignored.
- R6: Writing 0 to bit 4 clears ready; writing 1 to it leaves ready unchanged.
- R7: A `tod_match` or `ssec_match` pulse while running sets bit 6 or bit 7 respectively; writing 0 to a flag clears it, writing 1 leaves it unchanged.
- R8: `irq` is 1 exactly when (ready and bit 5), or (bit 6 and the in-force bit 1), or (bit 7 and the in-force bit 2).
- R9: With square-wave enable set and the clock running, `sqw_out` has a period of 2^LOG2_HZ counting cycles for rate 0, 2^(LOG2_HZ-9) for rate 1, and 8 for rates 2 and 3.
- R10: `sqw_out` is held at 0 when square-wave enable is 0 or `rtc_run` is 0.
- R11: `ctr_rd_valid` is 1 when bit 11 is 1, otherwise it follows ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-domain clock |
| bus_rst_n | input | 1 | Bus-domain synchronous reset, active low |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Current control/status word |
| cnt_clk | input | 1 | Counting-domain clock |
| cnt_rst_n | input | 1 | Counting-domain synchronous reset, active low |
| cnt_tick | input | 1 | One-cycle counter update strobe (counting domain) |
| tod_match | input | 1 | One-cycle time-of-day alarm match (counting domain) |
| ssec_match | input | 1 | One-cycle sub-second alarm match (counting domain) |
| rtc_run | output | 1 | Run enable as held in the counting domain |
| irq | output | 1 | Combined interrupt request |
| ctr_rd_valid | output | 1 | Counter read may be trusted |
| sqw_out | output | 1 | Square-wave output (counting domain) |

## Verification
The handshake is exercised with the permit bit clear, with it set but no guarded change, with a real enable change, and with writes landing while busy is high, which separates the permit guard from the busy freeze. Ready is driven by ticks while stopped and running, by software writes of 0 and of 1, and by a tick on an already-set flag, where seeing a low window proves the pre-update clear. Alarm flags are raised before their enables are in force, so the interrupt stays low through the busy window and rises only after it. The square wave is swept over all four rate codes with edge-to-edge counting, then with the enable and the run bit removed.

// File: rtl/rtc_cs_pkg.sv
// Package: bit positions of the control/status word, event indices for the
// counting-to-bus pulse channels, and the square-wave rate codes.
package rtc_cs_pkg;

    localparam int unsigned B_EN    = 0;
    localparam int unsigned B_TODIE = 1;
    localparam int unsigned B_SSIE  = 2;
    localparam int unsigned B_BUSY  = 3;
    localparam int unsigned B_RDY   = 4;
    localparam int unsigned B_RDYIE = 5;
    localparam int unsigned B_TODFL = 6;
    localparam int unsigned B_SSFL  = 7;
    localparam int unsigned B_SQWEN = 8;
    localparam int unsigned B_FSEL  = 9;
    localparam int unsigned B_ASYNC = 11;
    localparam int unsigned B_WREN  = 15;

    localparam int unsigned N_EV    = 4;
    localparam int unsigned EV_PRE  = 0;
    localparam int unsigned EV_POST = 1;
    localparam int unsigned EV_TOD  = 2;
    localparam int unsigned EV_SSEC = 3;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'd0,
        RATE_MID  = 2'd1,
        RATE_FAST = 2'd2,
        RATE_ALT  = 2'd3
    } rate_e;

endpackage

// File: rtl/rtc_sync2.sv
// Two-flop synchronizer for W independent quasi-static or toggle bits.
// Assumes each bit is either stable for several destination cycles or a
// toggle whose consumer tolerates two cycles of latency.
module rtc_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Capture the asynchronous input into two back-to-back flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/rtc_pulse_xfer.sv
// Moves single-cycle pulses from a source clock domain to a destination
// domain by toggling a level, synchronizing it and detecting its edges.
// Assumes the destination clock is fast enough to see every toggle.
module rtc_pulse_xfer (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);

    logic tgl_q;
    logic tgl_sync;
    logic tgl_last;

    // Flip the level once per source pulse.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) tgl_q <= 1'b0;
        else            tgl_q <= tgl_q ^ src_pulse;
    end

    rtc_sync2 #(.W(1)) u_sync (
        .clk  (dst_clk),
        .rst_n(dst_rst_n),
        .d    (tgl_q),
        .q    (tgl_sync)
    );

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) tgl_last <= 1'b0;
        else            tgl_last <= tgl_sync;
    end

    assign dst_pulse = tgl_sync ^ tgl_last;

endmodule

// File: rtl/rtc_sqw_gen.sv
// Square-wave generator in the counting domain. A free divider runs while
// the clock is enabled and is cleared while it is stopped; one divider bit
// is picked by the rate code. Assumes LOG2_HZ >= 13 so every tap exists.
module rtc_sqw_gen
    import rtc_cs_pkg::*;
#(
    parameter int unsigned LOG2_HZ = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       sqw_en,
    input  logic [1:0] rate,
    output logic       sqw
);

    localparam int unsigned TAP_SLOW = LOG2_HZ - 1;
    localparam int unsigned TAP_MID  = LOG2_HZ - 10;
    localparam int unsigned TAP_FAST = 2;

    logic [LOG2_HZ-1:0] div_q;
    logic               tap;

    // Divider counts while running and restarts from zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    // Pick the divider bit for the requested rate.
    always_comb begin
        unique case (rate_e'(rate))
            RATE_SLOW: tap = div_q[TAP_SLOW];
            RATE_MID:  tap = div_q[TAP_MID];
            default:   tap = div_q[TAP_FAST];
        endcase
    end

    // Register the output, forced low when disabled or stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) sqw <= 1'b0;
        else        sqw <= run & sqw_en & tap;
    end

endmodule

// File: rtl/rtc_ctrl_sync.sv
// Control/status word of a real-time clock spanning a bus domain and a slow
// counting domain. Run and alarm-enable changes are handed over with a toggle
// request/acknowledge handshake flagged by busy; counting-domain events come
// back as pulses. Assumes DATA_W >= 16 and that bus_clk is at least as fast
// as cnt_clk.
module rtc_ctrl_sync
    import rtc_cs_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned LOG2_HZ = 15
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cnt_clk,
    input  logic              cnt_rst_n,
    input  logic              cnt_tick,
    input  logic              tod_match,
    input  logic              ssec_match,
    output logic              rtc_run,
    output logic              irq,
    output logic              ctr_rd_valid,
    output logic              sqw_out
);

    // ---------------- bus-domain state ----------------
    logic       en_q, tod_ie_q, ss_ie_q;
    logic       tod_ie_eff, ss_ie_eff;
    logic       busy_q, req_q, ack_b;
    logic       rdy_q, rdy_ie_q, tod_fl_q, ss_fl_q;
    logic       sqw_en_q, async_q, wren_q;
    logic [1:0] rate_q;

    logic       wr_hit, en_ok, ie_ok;
    logic       en_nxt, tod_nxt, ss_nxt;
    logic       hs_start, hs_done;
    logic       unused_wdata;

    // ---------------- counting-domain state ----------------
    logic       req_c, seen_c, run_c, tick_d;
    logic [2:0] sqw_cfg_c;
    logic [N_EV-1:0] ev_src, ev_dst;
    logic       ev_post_b;

    assign wr_hit       = bus_sel & bus_wr;
    assign en_ok        = wr_hit & wren_q & ~busy_q;
    assign ie_ok        = wr_hit & ~busy_q;
    assign en_nxt       = en_ok ? bus_wdata[B_EN]    : en_q;
    assign tod_nxt      = ie_ok ? bus_wdata[B_TODIE] : tod_ie_q;
    assign ss_nxt       = ie_ok ? bus_wdata[B_SSIE]  : ss_ie_q;
    assign hs_start     = (en_nxt ^ en_q) | (tod_nxt ^ tod_ie_q) | (ss_nxt ^ ss_ie_q);
    assign hs_done      = busy_q & (ack_b == req_q);
    assign unused_wdata = ^bus_wdata;

    // Guarded bits, busy flag, request toggle and commit of the alarm enables.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            en_q       <= 1'b0;
            tod_ie_q   <= 1'b0;
            ss_ie_q    <= 1'b0;
            busy_q     <= 1'b0;
            req_q      <= 1'b0;
            tod_ie_eff <= 1'b0;
            ss_ie_eff  <= 1'b0;
        end else begin
            en_q     <= en_nxt;
            tod_ie_q <= tod_nxt;
            ss_ie_q  <= ss_nxt;
            if (hs_start) begin
                busy_q <= 1'b1;
                req_q  <= ~req_q;
            end else if (hs_done) begin
                busy_q     <= 1'b0;
                tod_ie_eff <= tod_ie_q;
                ss_ie_eff  <= ss_ie_q;
            end
        end
    end

    // Plain read/write configuration bits.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            rdy_ie_q <= 1'b0;
            sqw_en_q <= 1'b0;
            rate_q   <= RATE_SLOW;
            async_q  <= 1'b0;
            wren_q   <= 1'b0;
        end else if (wr_hit) begin
            rdy_ie_q <= bus_wdata[B_RDYIE];
            sqw_en_q <= bus_wdata[B_SQWEN];
            rate_q   <= bus_wdata[B_FSEL +: 2];
            async_q  <= bus_wdata[B_ASYNC];
            wren_q   <= bus_wdata[B_WREN];
        end
    end

    // Ready flag: pre-update clear, post-update set, software clear by 0.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n)                        rdy_q <= 1'b0;
        else if (ev_dst[EV_PRE])               rdy_q <= 1'b0;
        else if (ev_dst[EV_POST])              rdy_q <= 1'b1;
        else if (wr_hit && !bus_wdata[B_RDY])  rdy_q <= 1'b0;
    end

    // Alarm pending flags: set by match events, cleared by writing 0.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            tod_fl_q <= 1'b0;
            ss_fl_q  <= 1'b0;
        end else begin
            tod_fl_q <= ev_dst[EV_TOD]  | (tod_fl_q & ~(wr_hit & ~bus_wdata[B_TODFL]));
            ss_fl_q  <= ev_dst[EV_SSEC] | (ss_fl_q  & ~(wr_hit & ~bus_wdata[B_SSFL]));
        end
    end

    // Assemble the read word from the register bits.
    always_comb begin
        bus_rdata                = '0;
        bus_rdata[B_EN]          = en_q;
        bus_rdata[B_TODIE]       = tod_ie_q;
        bus_rdata[B_SSIE]        = ss_ie_q;
        bus_rdata[B_BUSY]        = busy_q;
        bus_rdata[B_RDY]         = rdy_q;
        bus_rdata[B_RDYIE]       = rdy_ie_q;
        bus_rdata[B_TODFL]       = tod_fl_q;
        bus_rdata[B_SSFL]        = ss_fl_q;
        bus_rdata[B_SQWEN]       = sqw_en_q;
        bus_rdata[B_FSEL +: 2]   = rate_q;
        bus_rdata[B_ASYNC]       = async_q;
        bus_rdata[B_WREN]        = wren_q;
    end

    assign irq          = (rdy_q & rdy_ie_q) | (tod_fl_q & tod_ie_eff) | (ss_fl_q & ss_ie_eff);
    assign ctr_rd_valid = async_q | rdy_q;

    // ---------------- handshake crossing ----------------
    rtc_sync2 #(.W(1)) u_req_sync (
        .clk  (cnt_clk),
        .rst_n(cnt_rst_n),
        .d    (req_q),
        .q    (req_c)
    );

    // Counting side: on a new request take the run bit and echo the request.
    always_ff @(posedge cnt_clk) begin
        if (!cnt_rst_n) begin
            seen_c <= 1'b0;
            run_c  <= 1'b0;
        end else if (req_c != seen_c) begin
            seen_c <= req_c;
            run_c  <= en_q;
        end
    end

    rtc_sync2 #(.W(1)) u_ack_sync (
        .clk  (bus_clk),
        .rst_n(bus_rst_n),
        .d    (seen_c),
        .q    (ack_b)
    );

    assign rtc_run = run_c;

    // ---------------- counting-domain events ----------------
    // Delay the gated tick by one counting cycle to mark the post-update point.
    always_ff @(posedge cnt_clk) begin
        if (!cnt_rst_n) tick_d <= 1'b0;
        else            tick_d <= cnt_tick & run_c;
    end

    assign ev_src[EV_PRE]  = cnt_tick & run_c;
    assign ev_src[EV_POST] = tick_d;
    assign ev_src[EV_TOD]  = tod_match & run_c;
    assign ev_src[EV_SSEC] = ssec_match & run_c;

    for (genvar gi = 0; gi < N_EV; gi++) begin : g_ev
        rtc_pulse_xfer u_xfer (
            .src_clk  (cnt_clk),
            .src_rst_n(cnt_rst_n),
            .src_pulse(ev_src[gi]),
            .dst_clk  (bus_clk),
            .dst_rst_n(bus_rst_n),
            .dst_pulse(ev_dst[gi])
        );
    end

    assign ev_post_b = ev_dst[EV_POST];

    // ---------------- square wave ----------------
    rtc_sync2 #(.W(3)) u_cfg_sync (
        .clk  (cnt_clk),
        .rst_n(cnt_rst_n),
        .d    ({sqw_en_q, rate_q}),
        .q    (sqw_cfg_c)
    );

    rtc_sqw_gen #(.LOG2_HZ(LOG2_HZ)) u_sqw (
        .clk   (cnt_clk),
        .rst_n (cnt_rst_n),
        .run   (run_c),
        .sqw_en(sqw_cfg_c[2]),
        .rate  (sqw_cfg_c[1:0]),
        .sqw   (sqw_out)
    );

endmodule

// File: rtl/rtc_ctrl_sync_chk.sv
// Assertion checker for rtc_ctrl_sync, attached by the bind at the end of
// this file. Observes internal register state of both clock domains.
module rtc_ctrl_sync_chk (
    input logic bus_clk,
    input logic bus_rst_n,
    input logic cnt_clk,
    input logic cnt_rst_n,
    input logic wr_hit,
    input logic wren_q,
    input logic busy_q,
    input logic en_q,
    input logic tod_ie_q,
    input logic ss_ie_q,
    input logic tod_ie_eff,
    input logic ss_ie_eff,
    input logic rdy_q,
    input logic ev_post_b,
    input logic run_c,
    input logic sqw_en_c,
    input logic sqw_out
);

    // R2: a write without permit, or during busy, leaves the run bit alone.
    assert_enable_guard_R2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_hit && (!wren_q || busy_q)) |=> $stable(en_q));

    // R3: busy only ever rises as a result of a write.
    assert_busy_cause_R3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(busy_q) |-> $past(wr_hit));

    // R3: while busy the three handed-over bits are frozen.
    assert_guard_frozen_R3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        busy_q |=> ($stable(en_q) && $stable(tod_ie_q) && $stable(ss_ie_q)));

    // R4: with no handshake open the in-force alarm enables match the word.
    assert_commit_match_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !busy_q |-> (tod_ie_eff == tod_ie_q && ss_ie_eff == ss_ie_q));

    // R5: ready is set only by a post-update event.
    assert_ready_source_R5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(rdy_q) |-> $past(ev_post_b));

    // R10: output goes low after the wave is disabled or the clock stopped.
    assert_sqw_quiet_R10: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
        (!run_c || !sqw_en_c) |=> !sqw_out);

endmodule

bind rtc_ctrl_sync rtc_ctrl_sync_chk chk_i (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .cnt_clk   (cnt_clk),
    .cnt_rst_n (cnt_rst_n),
    .wr_hit    (wr_hit),
    .wren_q    (wren_q),
    .busy_q    (busy_q),
    .en_q      (en_q),
    .tod_ie_q  (tod_ie_q),
    .ss_ie_q   (ss_ie_q),
    .tod_ie_eff(tod_ie_eff),
    .ss_ie_eff (ss_ie_eff),
    .rdy_q     (rdy_q),
    .ev_post_b (ev_post_b),
    .run_c     (run_c),
    .sqw_en_c  (sqw_cfg_c[2]),
    .sqw_out   (sqw_out)
);

// File: tb/rtc_ctrl_sync_tb.sv
// Self-checking bench: 125 MHz bus clock, counting clock at half that rate.
module rtc_ctrl_sync_tb_top;

    localparam int DW = 16;
    localparam logic [15:0] M_EN    = 16'h0001;
    localparam logic [15:0] M_TODIE = 16'h0002;
    localparam logic [15:0] M_SSIE  = 16'h0004;
    localparam logic [15:0] M_RDY   = 16'h0010;
    localparam logic [15:0] M_RDYIE = 16'h0020;
    localparam logic [15:0] M_TODFL = 16'h0040;
    localparam logic [15:0] M_SSFL  = 16'h0080;
    localparam logic [15:0] M_SQW   = 16'h0100;
    localparam logic [15:0] M_ASYNC = 16'h0800;
    localparam logic [15:0] M_WREN  = 16'h8000;
    localparam logic [15:0] KEEP    = M_RDY | M_TODFL | M_SSFL;

    logic          bus_clk = 1'b0;
    logic          cnt_clk = 1'b0;
    logic          bus_rst_n = 1'b0;
    logic          cnt_rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          cnt_tick = 1'b0;
    logic          tod_match = 1'b0;
    logic          ssec_match = 1'b0;
    logic          rtc_run, irq, ctr_rd_valid, sqw_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 bus_clk = ~bus_clk;
    always #8 cnt_clk = ~cnt_clk;

    rtc_ctrl_sync #(.DATA_W(DW), .LOG2_HZ(15)) dut_i (
        .bus_clk     (bus_clk),
        .bus_rst_n   (bus_rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cnt_clk     (cnt_clk),
        .cnt_rst_n   (cnt_rst_n),
        .cnt_tick    (cnt_tick),
        .tod_match   (tod_match),
        .ssec_match  (ssec_match),
        .rtc_run     (rtc_run),
        .irq         (irq),
        .ctr_rd_valid(ctr_rd_valid),
        .sqw_out     (sqw_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] d);
        @(negedge bus_clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
        @(negedge bus_clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic settle_bus(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100; i++) begin
            if (bus_rdata[3] == 1'b0) break;
            @(negedge bus_clk);
        end
    endtask

    // which: 0 tick, 1 time-of-day match, 2 sub-second match
    task automatic cnt_pulse(input int which);
        @(negedge cnt_clk);
        if (which == 0) cnt_tick = 1'b1;
        else if (which == 1) tod_match = 1'b1;
        else ssec_match = 1'b1;
        @(negedge cnt_clk);
        cnt_tick = 1'b0; tod_match = 1'b0; ssec_match = 1'b0;
    endtask

    // Count counting cycles from a real rising edge to the next rise (full)
    // or to the next fall (half). Returns -1 on timeout.
    task automatic measure(input bit full, output int n);
        int t;
        n = -1;
        t = 0;
        while (sqw_out != 1'b0 && t < 70000) begin @(negedge cnt_clk); t++; end
        while (sqw_out != 1'b1 && t < 70000) begin @(negedge cnt_clk); t++; end
        if (t >= 70000) return;
        n = 0;
        if (full) begin
            while (sqw_out == 1'b1 && n < 70000) begin @(negedge cnt_clk); n++; end
            while (sqw_out == 1'b0 && n < 70000) begin @(negedge cnt_clk); n++; end
        end else begin
            while (sqw_out == 1'b1 && n < 70000) begin @(negedge cnt_clk); n++; end
        end
    endtask

    task automatic quiet_sqw(input string req, input int cycles);
        int highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge cnt_clk);
            if (sqw_out) highs++;
        end
        chk(req, highs, 0);
    endtask

    initial begin
        repeat (190000) @(posedge bus_clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] base;
        logic [15:0] base2;
        int n;
        bit saw_low;
        bit saw_high;

        settle_bus(10);
        bus_rst_n = 1'b1;
        cnt_rst_n = 1'b1;
        settle_bus(2);

        // R1 reset state
        chk("R1 word", int'(bus_rdata), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 run", int'(rtc_run), 0);
        chk("R1 sqw", int'(sqw_out), 0);
        chk("R1 rdvalid", int'(ctr_rd_valid), 0);

        // R5 tick and R7 match ignored while stopped
        cnt_pulse(0);
        cnt_pulse(1);
        settle_bus(12);
        chk("R5 tick while stopped", int'(bus_rdata[4]), 0);
        chk("R7 match while stopped", int'(bus_rdata[6]), 0);

        // R2 enable without permit
        bus_write(KEEP | M_EN);
        settle_bus(2);
        chk("R2 enable w/o permit", int'(bus_rdata[0]), 0);
        chk("R3 no busy on ignored write", int'(bus_rdata[3]), 0);

        // permit only: no guarded change, no handshake
        bus_write(KEEP | M_WREN);
        chk("R2 permit bit", int'(bus_rdata[15]), 1);
        chk("R3 no busy w/o change", int'(bus_rdata[3]), 0);

        // R2/R3 accepted enable change
        bus_write(KEEP | M_WREN | M_EN);
        chk("R3 busy set", int'(bus_rdata[3]), 1);
        chk("R2 enable taken", int'(bus_rdata[0]), 1);
        // writes during busy: enable off and alarm enable on are ignored
        bus_write(KEEP | M_WREN | M_TODIE);
        chk("R3 still busy", int'(bus_rdata[3]), 1);
        wait_idle();
        chk("R3 busy cleared", int'(bus_rdata[3]), 0);
        chk("R3 enable frozen", int'(bus_rdata[0]), 1);
        chk("R3 alarm enable frozen", int'(bus_rdata[1]), 0);
        chk("R4 run in place", int'(rtc_run), 1);

        base = KEEP | M_WREN | M_EN;

        // R5 ready set by tick, R11 follows ready
        cnt_pulse(0);
        settle_bus(12);
        chk("R5 ready after tick", int'(bus_rdata[4]), 1);
        chk("R8 no irq w/o ready enable", int'(irq), 0);
        chk("R11 valid follows ready", int'(ctr_rd_valid), 1);

        // R6 write 1 keeps, write 0 clears
        bus_write(base);
        chk("R6 write 1 keeps", int'(bus_rdata[4]), 1);
        bus_write(base & ~M_RDY);
        chk("R6 write 0 clears", int'(bus_rdata[4]), 0);
        chk("R11 valid low", int'(ctr_rd_valid), 0);
        bus_write(base);
        chk("R6 write 1 no set", int'(bus_rdata[4]), 0);

        // R8 ready interrupt
        bus_write(base | M_RDYIE);
        cnt_pulse(0);
        settle_bus(12);
        chk("R5 ready again", int'(bus_rdata[4]), 1);
        chk("R8 ready irq", int'(irq), 1);

        // R5 pre-update clear on an already-set ready
        saw_low = 1'b0;
        saw_high = 1'b0;
        fork
            cnt_pulse(0);
            for (int i = 0; i < 30; i++) begin
                @(negedge bus_clk);
                if (!bus_rdata[4]) saw_low = 1'b1;
                else if (saw_low) saw_high = 1'b1;
            end
        join
        chk("R5 pre-update clear seen", int'(saw_low), 1);
        chk("R5 set after update", int'(saw_high), 1);

        // R11 free-running mode
        bus_write((base | M_RDYIE) & ~M_RDY);
        chk("R8 irq drops with ready", int'(irq), 0);
        bus_write(base | M_RDYIE | M_ASYNC);
        chk("R11 free-running valid", int'(ctr_rd_valid), 1);
        bus_write(base | M_RDYIE);
        chk("R11 sync invalid", int'(ctr_rd_valid), 0);

        // R7/R8/R4 time-of-day alarm
        cnt_pulse(1);
        settle_bus(12);
        chk("R7 tod flag set", int'(bus_rdata[6]), 1);
        chk("R8 tod irq gated", int'(irq), 0);
        bus_write(base | M_RDYIE | M_TODIE);
        chk("R3 busy on alarm enable", int'(bus_rdata[3]), 1);
        chk("R4 irq held during busy", int'(irq), 0);
        wait_idle();
        chk("R4 tod irq after busy", int'(irq), 1);
        bus_write((base | M_RDYIE | M_TODIE) & ~M_TODFL);
        chk("R7 tod flag cleared", int'(bus_rdata[6]), 0);
        chk("R8 irq after tod clear", int'(irq), 0);
        bus_write(base | M_RDYIE | M_TODIE);
        chk("R7 write 1 no set", int'(bus_rdata[6]), 0);

        // R7/R8 sub-second alarm
        cnt_pulse(2);
        settle_bus(12);
        chk("R7 ssec flag set", int'(bus_rdata[7]), 1);
        chk("R8 ssec irq gated", int'(irq), 0);
        base2 = base | M_RDYIE | M_TODIE | M_SSIE;
        bus_write(base2);
        wait_idle();
        chk("R8 ssec irq", int'(irq), 1);
        bus_write(base2 & ~M_SSFL);
        chk("R7 ssec flag cleared", int'(bus_rdata[7]), 0);
        chk("R8 irq after ssec clear", int'(irq), 0);

        // R9 rate sweep
        bus_write(base2 | M_SQW | (16'd2 << 9));
        repeat (10) @(negedge cnt_clk);
        measure(1'b1, n);
        chk("R9 rate 2 period", n, 8);
        bus_write(base2 | M_SQW | (16'd3 << 9));
        repeat (10) @(negedge cnt_clk);
        measure(1'b1, n);
        chk("R9 rate 3 period", n, 8);
        bus_write(base2 | M_SQW | (16'd1 << 9));
        repeat (10) @(negedge cnt_clk);
        measure(1'b1, n);
        chk("R9 rate 1 period", n, 64);
        bus_write(base2 | M_SQW);
        repeat (10) @(negedge cnt_clk);
        measure(1'b0, n);
        chk("R9 rate 0 half period", n, 16384);

        // R10 disabled wave, then stopped clock
        bus_write(base2 | (16'd2 << 9));
        repeat (10) @(negedge cnt_clk);
        quiet_sqw("R10 wave disabled", 100);
        bus_write((base2 & ~M_EN) | M_SQW | (16'd2 << 9));
        wait_idle();
        chk("R4 run stopped", int'(rtc_run), 0);
        repeat (4) @(negedge cnt_clk);
        quiet_sqw("R10 clock stopped", 100);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule